// File: doc/BRIEF.md
# Scan Load Decompressor with Per-Pattern Mode Control

This block turns one serial scan-in stream into sixteen chain-load bits that feed the internal scan chains of a compressed test architecture. Test data passes through an eight-stage input shifter that advances on the falling edge of the scan clock while scan enable is high. The four stages farthest from scan-in act as load inputs 0 to 3. A combinational spreader routes these four inputs to the sixteen chains. Which input reaches which chain depends on a mode.

The routing follows a base-4 numbering. Each chain number from 0 to 15 is written as two base-4 digits. In a given mode, the matching digit names the load input that drives the chain. The routing gives every pair of chains a different source in at least one mode. The mode is set once per pattern. A bank of level-sensitive latches is open while scan enable is low and closed during shifting. While open, it copies the same four far-end stages of the shifter. The test stream therefore carries its own configuration for the next pattern. One latched bit selects the mode. A second latched bit is spare. The remaining two bits leave the block as chain-mask controls for the unload side.

Top module: `scan_load_decomp`

## Requirements
- R1: While `rst` is high at a falling scan-clock edge, all eight shifter stages clear to 0. While `rst` is high, the control latches read mode 0, and `mask_ctrl` is 0.
- R2: At a falling edge with `scan_en` high and `rst` low, stage 0 takes `scan_in` and each stage i (1 to 7) takes the old value of stage i-1.
- R3: At a falling edge with `scan_en` low, the shifter keeps its contents.
- R4: While `scan_en` is low, the control latches follow shifter stages 7..4. Control bit 0 is stage 4, bit 1 is stage 5, bit 2 is stage 6 and bit 3 is stage 7. While `scan_en` is high, the latches hold the value they had when `scan_en` rose. `mask_ctrl[1:0]` equals control bits 3..2.
- R5: Load input k is shifter stage 4+k. Control bit 0 is the mode. In mode 0, chain c is driven by load input c mod 4. In mode 1, chain c is driven by load input c div 4. For example, chain 2 takes input 2 in mode 0 and input 0 in mode 1.
- R6: Chains 0, 5, 10 and 15 are driven by load inputs 0, 1, 2 and 3 in either mode.
- R7: Control bit 1 has no effect on `chain_load`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| scan_clk | input | 1 | Scan clock. The shifter acts on its falling edge. |
| rst | input | 1 | Synchronous active-high reset. It also forces the control latches to zero. |
| scan_en | input | 1 | High: shift. Low: capture, with the control latches open. |
| scan_in | input | 1 | Serial test data. |
| chain_load | output | 16 | One load bit per internal scan chain. |
| mask_ctrl | output | 2 | Latched chain-mask controls for the unload side. |

## Verification
Several checks run on every cycle:
- the reset clear of the shifter;
- the one-stage advance while shifting and the freeze during capture;
- the latch transparency toward stages 7..4 while scan enable is low, and the latch hold while it stays high;
- the mode-independent wiring of chains 0, 5, 10 and 15.

The mode-dependent base-4 routing of the other twelve chains can only be shown by the bench's scenarios. The same holds for the fact that the spare control bit has no effect. The bench's reference model recomputes the routing from chain digits on every cycle. It does so across programmed patterns, random streams and both modes.

// File: rtl/scan_decomp_pkg.sv
package scan_decomp_pkg;

  // Base-radix digit 'pos' of a chain number.
  function automatic int digit_of(input int chain, input int pos, input int radix);
    int v;
    v = chain;
    for (int i = 0; i < pos; i++) v = v / radix;
    return v % radix;
  endfunction

  // A chain whose digits are all equal sees the same source in every mode.
  function automatic bit is_uniform(input int chain, input int modes, input int radix);
    bit same;
    same = 1'b1;
    for (int m = 1; m < modes; m++)
      if (digit_of(chain, m, radix) != digit_of(chain, 0, radix)) same = 1'b0;
    return same;
  endfunction

  // Number of the chain whose digits all equal k.
  function automatic int uniform_chain(input int k, input int modes, input int radix);
    int acc;
    int w;
    acc = 0;
    w = 1;
    for (int m = 0; m < modes; m++) begin
      acc = acc + k * w;
      w = w * radix;
    end
    return acc;
  endfunction

endpackage

// File: rtl/scan_in_shifter.sv
module scan_in_shifter #(
  parameter int LEN = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           shift_en,
  input  logic           din,
  output logic [LEN-1:0] stages
);

  // Trailing-edge shifter: stage 0 is nearest the serial input.
  always_ff @(negedge clk) begin
    if (rst)
      stages <= '0;
    else if (shift_en)
      stages <= {stages[LEN-2:0], din};
  end

endmodule

// File: rtl/ctrl_latch_bank.sv
module ctrl_latch_bank #(
  parameter int W = 4
) (
  input  logic         rst,
  input  logic         open_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  // Level-sensitive: transparent while open_en is high, frozen otherwise.
  always_latch begin
    if (rst)
      q <= '0;
    else if (open_en)
      q <= d;
  end

endmodule

// File: rtl/load_spreader.sv
module load_spreader
  import scan_decomp_pkg::*;
#(
  parameter int N_LOADS  = 4,
  parameter int N_MODES  = 2,
  parameter int N_CHAINS = 16,
  parameter int SEL_W    = 1
) (
  input  logic [N_LOADS-1:0]  load_i,
  input  logic [SEL_W-1:0]    mode_sel,
  output logic [N_CHAINS-1:0] chain_o
);

  for (genvar c = 0; c < N_CHAINS; c++) begin : g_chain
    if (is_uniform(c, N_MODES, N_LOADS)) begin : g_fixed
      // Same source in every mode: plain wire, no selector.
      localparam int SRC = digit_of(c, 0, N_LOADS);
      assign chain_o[c] = load_i[SRC];
    end else begin : g_muxed
      logic [N_MODES-1:0] cand;
      for (genvar m = 0; m < N_MODES; m++) begin : g_mode
        localparam int SRC = digit_of(c, m, N_LOADS);
        assign cand[m] = load_i[SRC];
      end
      assign chain_o[c] = cand[mode_sel];
    end
  end

endmodule

// File: rtl/scan_load_decomp.sv
module scan_load_decomp #(
  parameter int SHIFT_LEN = 8,
  parameter int N_LOADS   = 4,
  parameter int N_MODES   = 2,
  parameter int MODE_W    = 2,
  parameter int MASK_W    = 2
) (
  input  logic                    scan_clk,
  input  logic                    rst,
  input  logic                    scan_en,
  input  logic                    scan_in,
  output logic [N_LOADS**N_MODES-1:0] chain_load,
  output logic [MASK_W-1:0]       mask_ctrl
);

  localparam int N_CHAINS = N_LOADS ** N_MODES;
  localparam int CTRL_W   = MODE_W + MASK_W;
  localparam int SEL_W    = (N_MODES > 1) ? $clog2(N_MODES) : 1;

  logic [SHIFT_LEN-1:0] stage_q;
  logic [CTRL_W-1:0]    ctrl_q;
  logic [SEL_W-1:0]     mode_sel;

  scan_in_shifter #(.LEN(SHIFT_LEN)) u_shift (
    .clk      (scan_clk),
    .rst      (rst),
    .shift_en (scan_en),
    .din      (scan_in),
    .stages   (stage_q)
  );

  ctrl_latch_bank #(.W(CTRL_W)) u_ctrl (
    .rst     (rst),
    .open_en (~scan_en),
    .d       (stage_q[SHIFT_LEN-1 -: CTRL_W]),
    .q       (ctrl_q)
  );

  assign mode_sel  = ctrl_q[SEL_W-1:0];
  assign mask_ctrl = ctrl_q[CTRL_W-1:MODE_W];

  if (MODE_W > SEL_W) begin : g_spare
    logic spare_mode_unused;
    assign spare_mode_unused = ^ctrl_q[MODE_W-1:SEL_W];
  end

  if (SHIFT_LEN > N_LOADS) begin : g_near
    logic near_stage_unused;
    assign near_stage_unused = ^stage_q[SHIFT_LEN-N_LOADS-1:0];
  end

  load_spreader #(
    .N_LOADS  (N_LOADS),
    .N_MODES  (N_MODES),
    .N_CHAINS (N_CHAINS),
    .SEL_W    (SEL_W)
  ) u_spread (
    .load_i   (stage_q[SHIFT_LEN-1 -: N_LOADS]),
    .mode_sel (mode_sel),
    .chain_o  (chain_load)
  );

endmodule

// File: rtl/scan_load_decomp_checker.sv
module scan_load_decomp_checker
  import scan_decomp_pkg::*;
#(
  parameter int SHIFT_LEN = 8,
  parameter int N_LOADS   = 4,
  parameter int N_MODES   = 2,
  parameter int MASK_W    = 2
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        scan_en,
  input logic [SHIFT_LEN-1:0]        stage_q,
  input logic [N_LOADS**N_MODES-1:0] chain_load,
  input logic [MASK_W-1:0]           mask_ctrl
);

  // R1: reset clears the shifter at the following trailing edge
  a_r1_stage_clear: assert property (@(negedge clk) rst |=> (stage_q == '0));

  // R1: mask controls read zero while reset has been held
  a_r1_mask_clear: assert property (@(posedge clk) (rst && $past(rst)) |-> (mask_ctrl == '0));

  // R2: one-stage advance while shifting
  a_r2_advance: assert property (@(negedge clk) disable iff (rst)
    scan_en |=> (stage_q[SHIFT_LEN-1:1] == $past(stage_q[SHIFT_LEN-2:0])));

  // R3: frozen during capture
  a_r3_freeze: assert property (@(negedge clk) disable iff (rst)
    !scan_en |=> $stable(stage_q));

  // R4: latches open while scan enable is low
  a_r4_transparent: assert property (@(posedge clk) disable iff (rst)
    !scan_en |-> (mask_ctrl == stage_q[SHIFT_LEN-1 -: MASK_W]));

  // R4: latches closed across a shifting interval
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (scan_en && $past(scan_en) && !$past(rst)) |-> $stable(mask_ctrl));

  // R6: uniform-digit chains are wired straight to their load input
  for (genvar k = 0; k < N_LOADS; k++) begin : g_fix
    localparam int CH = uniform_chain(k, N_MODES, N_LOADS);
    a_r6_fixed_route: assert property (@(posedge clk) disable iff (rst)
      chain_load[CH] == stage_q[SHIFT_LEN-N_LOADS+k]);
  end

endmodule

bind scan_load_decomp scan_load_decomp_checker #(
  .SHIFT_LEN (SHIFT_LEN),
  .N_LOADS   (N_LOADS),
  .N_MODES   (N_MODES),
  .MASK_W    (MASK_W)
) u_checker (
  .clk        (scan_clk),
  .rst        (rst),
  .scan_en    (scan_en),
  .stage_q    (stage_q),
  .chain_load (chain_load),
  .mask_ctrl  (mask_ctrl)
);

// File: tb/test_scan_load_decomp.sv
module test_scan_load_decomp;

  localparam int CLK_PERIOD = 10;

  logic        scan_clk = 1'b0;
  logic        rst      = 1'b1;
  logic        scan_en  = 1'b0;
  logic        scan_in  = 1'b0;
  logic [15:0] chain_load;
  logic [1:0]  mask_ctrl;

  int n_cmp = 0;
  int n_bad = 0;

  bit sr[$];          // sr[i] = bit shifted in i shifts ago (stage i)
  bit [3:0] ctrl_m;   // model of latched control bits

  scan_load_decomp i_scan_load_decomp (
    .scan_clk   (scan_clk),
    .rst        (rst),
    .scan_en    (scan_en),
    .scan_in    (scan_in),
    .chain_load (chain_load),
    .mask_ctrl  (mask_ctrl)
  );

  always #(CLK_PERIOD/2) scan_clk = ~scan_clk;

  function automatic bit [15:0] expect_chains();
    bit [15:0] e;
    for (int c = 0; c < 16; c++) begin
      int dg;
      dg = ctrl_m[0] ? (c / 4) : (c % 4);
      e[c] = sr[4 + dg];
    end
    return e;
  endfunction

  task automatic check_val(input string tag, input logic [15:0] act, input logic [15:0] exp_v);
    n_cmp++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp_v, $time);
    end
  endtask

  // Drive one scan clock period, update the model, compare after the falling edge.
  task automatic step(input bit se, input bit si, input bit r, input string tag);
    scan_en = se;
    scan_in = si;
    rst     = r;
    @(negedge scan_clk);
    if (r) begin
      foreach (sr[i]) sr[i] = 1'b0;
    end else if (se) begin
      sr.push_front(si);
      void'(sr.pop_back());
    end
    if (r) ctrl_m = 4'h0;
    else if (!se) ctrl_m = {sr[7], sr[6], sr[5], sr[4]};
    #(CLK_PERIOD/4);
    check_val({tag, " chain_load"}, chain_load, expect_chains());
    check_val({tag, " mask_ctrl"}, {14'd0, mask_ctrl}, {14'd0, ctrl_m[3:2]});
    @(posedge scan_clk);
  endtask

  // Shift a control nibble plus four data bits, then capture twice.
  task automatic program_pattern(input bit [3:0] ctrl, input bit [3:0] data);
    for (int i = 3; i >= 0; i--) step(1'b1, ctrl[i], 1'b0, "R2 shift");
    for (int i = 3; i >= 0; i--) step(1'b1, data[i], 1'b0, "R2 shift");
    step(1'b0, 1'b0, 1'b0, "R4 latch open");
    step(1'b0, 1'b1, 1'b0, "R3 capture hold");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) sr.push_back(1'b0);
    ctrl_m = 4'h0;

    // R1 reset state
    step(1'b0, 1'b0, 1'b1, "R1 reset");
    step(1'b0, 1'b0, 1'b1, "R1 reset");

    // Fill with ones, then reset again: shifter must clear
    for (int i = 0; i < 8; i++) step(1'b1, 1'b1, 1'b0, "R2 fill");
    step(1'b1, 1'b1, 1'b1, "R1 reset clears");
    check_val("R1 all chains zero", chain_load, 16'h0000);

    // Mode 0, masks 2'b10
    program_pattern(4'b1000, 4'b1011);
    for (int i = 0; i < 16; i++) step(1'b1, 1'(i % 3 == 0), 1'b0, "R5 mode0 stream");
    check_val("R6 chain5 is input1", {15'd0, chain_load[5]}, {15'd0, sr[5]});

    // Mode 1, masks 2'b01
    program_pattern(4'b0101, 4'b0110);
    for (int i = 0; i < 16; i++) step(1'b1, 1'(i % 2), 1'b0, "R5 mode1 stream");
    check_val("R5 chain2 mode1 is input0", {15'd0, chain_load[2]}, {15'd0, sr[4]});
    check_val("R6 chain10 is input2", {15'd0, chain_load[10]}, {15'd0, sr[6]});

    // Spare mode bit set, low mode bit clear: still mode 0
    program_pattern(4'b0010, 4'b1100);
    for (int i = 0; i < 12; i++) step(1'b1, 1'(i % 4 == 1), 1'b0, "R7 spare bit");
    check_val("R7 chain2 stays mode0 (input2)", {15'd0, chain_load[2]}, {15'd0, sr[6]});
    check_val("R7 chain7 stays mode0 (input3)", {15'd0, chain_load[7]}, {15'd0, sr[7]});

    // Random patterns in both modes
    for (int p = 0; p < 24; p++) begin
      program_pattern(4'($urandom), 4'($urandom));
      for (int i = 0; i < 20; i++) step(1'b1, 1'($urandom), 1'b0, "R5 random stream");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule